// File: doc/BRIEF.md
# Lockable Watchdog Timer

A down-counting watchdog that runs from a slow tick input. It starts counting as soon as reset is released, using the longest timeout and a reset request as its default action. Software has exactly one chance to reprogram it by writing a mode word. That word sets the reload value, a restart window, the fault action (interrupt, reset request, both, or neither), optional halting while the core is in debug or idle, and a disable. After that single write the mode is frozen until the next reset. A disable written at boot therefore stays in force until then.

Software keeps the timer alive by writing a keyed restart command. A restart issued too early, while the counter is still above the window value, counts as a fault. A status word tells a shared interrupt handler whether an underflow or an early restart happened. The status word clears when it is read.

Top module: `wdog_once`

## Requirements
- R1: The mode word (address 1) accepts only the first write after reset. Later writes leave it unchanged, and reading address 1 returns the stored word masked to its defined bits (mask 0x3FFF_BFFF).
- R2: A write to the mode word loads the counter at once with bits 11:0 of the written data. The next underflow then comes after that value plus one ticks.
- R3: After reset the mode word reads 0x0FFF_2FFF: reload 0xFFF, window 0xFFF, reset request on, interrupt off. The counter starts at 0xFFF and is already running.
- R4: A tick that arrives with the counter at zero is an underflow. It sets status bit 0 and reloads the counter from mode bits 11:0. If mode bit 13 is set, rst_req pulses high for one clock in the following cycle.
- R5: irq is a level. It is high while status bit 0 or bit 1 is set and mode bit 12 is set.
- R6: Reading the status word (address 2) returns the error flag in bit 1 and the underflow flag in bit 0, and clears both. A flag raised in the same cycle as the read stays set.
- R7: A write to address 0 with 0xA5 in bits 31:24 and bit 0 set reloads the counter. A write with any other key does nothing.
- R8: A keyed restart while the counter is greater than the window (mode bits 27:16) leaves the counter unchanged. It sets status bit 1 and takes the same rst_req and irq actions as an underflow.
- R9: With mode bit 28 set the counter holds while dbg_active is high. With mode bit 29 set it holds while cpu_idle is high.
- R10: With mode bit 15 set the counter stops and restarts are ignored. irq and rst_req stay low until the next reset.
- R11: bus_rdata is zero when bus_rd is low and when address 0 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-clock slow tick enable |
| dbg_active | input | 1 | Core is halted in debug |
| cpu_idle | input | 1 | Core is idle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register select: 0 restart, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Fault interrupt level |
| rst_req | output | 1 | One-clock reset request pulse |

## Verification
The counter value is hidden, so a wrong count shows at the ports only as an irq edge or an rst_req pulse one tick early or late. That can be as long as 4097 ticks after the fault, which is why the default timeout is run in full. A wrong lock or mode state appears on the very next read of address 1. It also appears at the next fault, as the wrong action. A status flag that fails to clear, or one that is lost in a read/set collision, shows on irq within one cycle. The reference model therefore compares all three outputs on every clock.

// File: rtl/wdog_once.sv
module wdog_once #(
  parameter int          CNT_W  = 12,
  parameter int          ADDR_W = 2,
  parameter logic [7:0]  KEY    = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dbg_active,
  input  logic              cpu_idle,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int B_IRQ = 12, B_RST = 13, B_DIS = 15, DLT_LSB = 16, B_DBG = 28, B_IDLE = 29;
  localparam logic [31:0] CNT_ONES = 32'((64'd1 << CNT_W) - 1);
  localparam logic [31:0] MASK = CNT_ONES | (CNT_ONES << DLT_LSB) | (32'd1 << B_IRQ)
                               | (32'd1 << B_RST) | (32'd1 << B_DIS) | (32'd1 << B_DBG) | (32'd1 << B_IDLE);
  localparam logic [31:0] MODE_RST = CNT_ONES | (CNT_ONES << DLT_LSB) | (32'd1 << B_RST);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(0), A_MODE = ADDR_W'(1), A_STAT = ADDR_W'(2);

  logic [31:0]      mode_q;
  logic             locked_q;
  logic [CNT_W-1:0] cnt_q;
  logic             unf_q, err_q, rst_req_q;

  wire [CNT_W-1:0] reload = mode_q[CNT_W-1:0];
  wire [CNT_W-1:0] delta  = mode_q[DLT_LSB +: CNT_W];
  wire dis      = mode_q[B_DIS];
  wire mode_wr  = bus_wr && bus_addr == A_MODE && !locked_q;
  wire kick     = bus_wr && bus_addr == A_KICK && bus_wdata[31:24] == KEY && bus_wdata[0] && !dis;
  wire kick_err = kick && cnt_q > delta;
  wire kick_ok  = kick && !kick_err;
  wire halted   = (mode_q[B_DBG] && dbg_active) || (mode_q[B_IDLE] && cpu_idle);
  wire step     = tick && !dis && !halted && !mode_wr && !kick_ok;
  wire unf      = step && cnt_q == '0;
  wire fault    = unf || kick_err;
  wire st_rd    = bus_rd && bus_addr == A_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RST;
      locked_q  <= 1'b0;
      cnt_q     <= '1;
      unf_q     <= 1'b0;
      err_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (mode_wr) begin
        mode_q   <= bus_wdata & MASK;
        locked_q <= 1'b1;
      end
      if (mode_wr)             cnt_q <= bus_wdata[CNT_W-1:0];
      else if (kick_ok || unf) cnt_q <= reload;
      else if (step)           cnt_q <= cnt_q - 1'b1;
      unf_q     <= unf || (unf_q && !st_rd);
      err_q     <= kick_err || (err_q && !st_rd);
      rst_req_q <= fault && mode_q[B_RST];
    end
  end

  assign irq     = (unf_q || err_q) && mode_q[B_IRQ] && !dis;
  assign rst_req = rst_req_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_MODE)      bus_rdata = mode_q;
      else if (bus_addr == A_STAT) bus_rdata = {30'd0, err_q, unf_q};
    end
  end
endmodule

module wdog_once_chk #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              dbg_active,
  input logic [31:0]       mode_q,
  input logic              locked_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              irq,
  input logic              rst_req
);
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode_q)); // R1
  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> locked_q); // R1
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[15] |-> (!irq && !rst_req)); // R10
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && mode_q[28] && !bus_wr) |=> $stable(cnt_q)); // R9
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(mode_q[13])); // R4
endmodule

bind wdog_once wdog_once_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .dbg_active(dbg_active), .mode_q(mode_q), .locked_q(locked_q),
  .cnt_q(cnt_q), .irq(irq), .rst_req(rst_req)
);

// File: tb/test_wdog_once.sv
module test_wdog_once;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, dbg = 1'b0, idle = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic irq, rst_req;

  wdog_once i_wdog_once (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_active(dbg), .cpu_idle(idle),
    .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  localparam logic [31:0] MASK = 32'h3FFF_BFFF;
  localparam logic [31:0] MDEF = 32'h0FFF_2FFF;
  int compared = 0, mismatched = 0, cycles = 0;
  string cur = "R3";

  logic [31:0] m_mode;
  int m_cnt;
  bit m_lock, m_unf, m_err, m_rst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = MDEF; m_lock = 0; m_cnt = 4095; m_unf = 0; m_err = 0; m_rst = 0;
    end else begin
      bit mwr, dis, kick, rd_st, su, se, fault, halted, reloaded;
      int reload, delta;
      mwr = wr && addr == 2'd1 && !m_lock;
      dis = m_mode[15];
      kick = wr && addr == 2'd0 && wdata[31:24] == 8'hA5 && wdata[0] && !dis;
      rd_st = rd && addr == 2'd2;
      halted = (m_mode[28] && dbg) || (m_mode[29] && idle);
      reload = int'(m_mode[11:0]);
      delta = int'(m_mode[27:16]);
      su = 0; se = 0; fault = 0; reloaded = 0;
      if (mwr) begin
        m_mode = wdata & MASK; m_lock = 1; m_cnt = int'(wdata[11:0]);
      end else begin
        if (kick) begin
          if (m_cnt > delta) begin se = 1; fault = 1; end
          else begin m_cnt = reload; reloaded = 1; end
        end
        if (!reloaded && tick && !dis && !halted) begin
          if (m_cnt == 0) begin su = 1; fault = 1; m_cnt = reload; end
          else m_cnt = m_cnt - 1;
        end
      end
      m_unf = su || (m_unf && !rd_st);
      m_err = se || (m_err && !rd_st);
      m_rst = fault && m_mode[13];
    end
  end

  always @(posedge clk) begin
    logic [31:0] exp_rd;
    logic exp_irq;
    #2;
    exp_irq = (m_unf || m_err) && m_mode[12] && !m_mode[15];
    exp_rd = 32'd0;
    if (rd && addr == 2'd1) exp_rd = m_mode;
    if (rd && addr == 2'd2) exp_rd = {30'd0, m_err, m_unf};
    compared += 3;
    if (irq !== exp_irq) begin
      mismatched++; $display("FAIL %s irq got %0b exp %0b", cur, irq, exp_irq);
    end
    if (rst_req !== m_rst) begin
      mismatched++; $display("FAIL %s rst_req got %0b exp %0b", cur, rst_req, m_rst);
    end
    if (rdata !== exp_rd) begin
      mismatched++; $display("FAIL %s rdata got %h exp %h", cur, rdata, exp_rd);
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired in %s", cur);
      finish_run();
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_w(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; wdata = 32'd0;
  endtask

  task automatic bus_r(logic [1:0] a);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick = 0; dbg = 0; idle = 0;
    cyc(2); rst_n = 1;
  endtask

  initial begin
    cyc(3); rst_n = 1;
    cur = "R3"; bus_r(2'd1); bus_r(2'd2);
    tick = 1; cyc(4100); tick = 0;
    cur = "R11"; bus_r(2'd0); addr = 2'd1; cyc(2);

    do_reset();
    cur = "R2"; tick = 1; cyc(30);
    bus_w(2'd1, 32'h0FFF_3005);
    cur = "R1"; bus_w(2'd1, 32'h0000_0FFF); bus_r(2'd1);
    cur = "R4"; cyc(10);
    cur = "R5"; cyc(3);
    cur = "R6"; bus_r(2'd2); cyc(3);
    for (int i = 0; i < 20; i++) bus_r(2'd2);
    cur = "R7"; bus_w(2'd0, 32'h5A00_0001); cyc(2);
    bus_w(2'd0, 32'hA500_0000);
    for (int i = 0; i < 8; i++) begin cyc(2); bus_w(2'd0, 32'hA500_0001); end
    cyc(10); tick = 0;

    do_reset();
    cur = "R8"; bus_w(2'd1, 32'h0005_300A);
    bus_w(2'd0, 32'hA500_0001); cyc(2); bus_r(2'd2);
    tick = 1; cyc(6); tick = 0;
    bus_w(2'd0, 32'hA500_0001); bus_r(2'd2);
    tick = 1; cyc(20); tick = 0;

    do_reset();
    cur = "R9"; bus_w(2'd1, 32'h3FFF_3003);
    dbg = 1; tick = 1; cyc(10); dbg = 0; cyc(2);
    idle = 1; cyc(10); bus_w(2'd0, 32'hA500_0001); cyc(4);
    idle = 0; cyc(10); bus_r(2'd2); tick = 0;

    do_reset();
    cur = "R10"; bus_w(2'd1, 32'h0FFF_B002);
    tick = 1; cyc(20); bus_w(2'd0, 32'hA500_0001);
    bus_w(2'd1, 32'h0FFF_3001); cyc(20); bus_r(2'd1); bus_r(2'd2);
    tick = 0; cyc(2);
    finish_run();
  end
endmodule